// File: doc/BRIEF.md
# One-Bit Stereo Stream Receiver

This block takes a stereo one-bit oversampled audio stream from an external decoder and turns it into one recovered bit per channel, marked by a single-cycle valid strobe. Everything runs in the master clock domain. The bit clock, phase reference and the two data lines are passed through a two-flop synchroniser, and rising edges of the bit clock are found after that synchroniser.

A mode input selects one of two capture schemes. In plain capture, both data lines are sampled on every rising bit-clock edge. In phase-modulated capture, the data clock runs at twice the bit rate and a phase reference at the bit rate splits each bit period into a phase-high half followed by a phase-low half. One half carries the bit and the other half carries its complement. A variant input chooses which half carries the bit, and a mismatch in the complement is flagged.

The block can also generate the clocks itself. In master mode it divides the master clock by 4, 8 or 12 to make the bit clock, and it makes the phase reference when phase-modulated capture is on. In master mode the variant is fixed to the phase-high carrier, and the external clock pins are ignored. In slave mode the clock outputs stay low.

Top module: `dsd_rx`

## Requirements
- R1: While reset is low, and in the first cycle after it is released with idle inputs, `bit_valid`, `pm_err`, `left_bit`, `right_bit`, `sclk_out` and `phase_out` are all 0.
- R2: With `pm_en`=0, each rising edge of the selected bit clock captures `ldata_in` and `rdata_in`. The captured pair appears on `left_bit`/`right_bit` with `bit_valid` high for exactly one cycle, three master-clock rising edges after the first edge that samples the high bit clock.
- R3: With `pm_en`=0, toggling `phase_in` has no effect on the recovered bits or on `bit_valid`.
- R4: With `pm_en`=1 and `pm_variant`=0, the bit is the data sampled at the rising clock edge where the phase is 1. It is emitted, with `bit_valid`, at the next rising clock edge where the phase is 0.
- R5: With `pm_en`=1 and `pm_variant`=1, the bit is the data sampled at the phase-0 edge, and it is emitted at that same edge.
- R6: In phase-modulated capture, `pm_err` rises together with `bit_valid` when, on either channel, the two halves of a bit period are not complements of each other. `pm_err` stays 0 in plain capture.
- R7: In master mode with `pm_en`=0, `sclk_out` has a period of 4, 8 or 12 master cycles for `ratio_sel` 0, 1 or 2. A `ratio_sel` of 3 gives a period of 4. `phase_out` stays 0, and the data is captured as in R2.
- R8: In master mode with `pm_en`=1, `sclk_out` has half that period. `phase_out` has the full period, and each of its rising edges coincides with a rising edge of `sclk_out`.
- R9: In master mode, `pm_variant`, `sclk_in` and `phase_in` are ignored, and the phase-high half always carries the bit.
- R10: With `master_en`=0, `sclk_out` and `phase_out` are 0.
- R11: In phase-modulated capture, a phase-0 clock edge that is not preceded by a phase-1 edge since the last emitted bit (or since reset) produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and phase reference; 0: accept them |
| pm_en | input | 1 | 1: phase-modulated capture; 0: plain capture |
| pm_variant | input | 1 | Slave only: 0 = phase-high half carries the bit, 1 = phase-low half carries it |
| ratio_sel | input | 2 | Master divide: 0 gives 4, 1 gives 8, 2 gives 12, 3 gives 4 |
| sclk_in | input | 1 | External bit/data clock (slave mode) |
| phase_in | input | 1 | External phase reference (slave mode) |
| ldata_in | input | 1 | Left-channel data line |
| rdata_in | input | 1 | Right-channel data line |
| sclk_out | output | 1 | Generated bit/data clock (master mode) |
| phase_out | output | 1 | Generated phase reference (master, phase-modulated) |
| left_bit | output | 1 | Recovered left bit |
| right_bit | output | 1 | Recovered right bit |
| bit_valid | output | 1 | One-cycle strobe for a recovered pair |
| pm_err | output | 1 | Complement mismatch, valid with `bit_valid` |

## Verification
Every recovered pair comes out three master-clock rising edges after the edge that first samples a rising bit clock. That bit clock is either the external pin or the internal divider output. The same delay applies to the phase-0 edge that closes a phase-modulated bit period.

The slave-mode driver holds each data level for several cycles around the clock rise. It checks that `bit_valid` is still low at the first and second falling edges after the rise and high at the third. It also pushes the expected pair before the rise, and the monitor pops that pair on the falling edge where the strobe is seen.

In master mode, the bench watches `sclk_out` on falling edges. It changes the data only after an observed fall, and it queues the expected pair at each observed rise, well before the three-edge delay has passed.

// File: rtl/dsd_rx_pkg.sv
// Shared types and helpers for the one-bit stream receiver.
package dsd_rx_pkg;
    localparam int DIV_W = 4;
    typedef logic [DIV_W-1:0] div_t;

    // Map the master divide select to master cycles per bit-clock period.
    function automatic div_t ratio_div(input logic [1:0] sel);
        case (sel)
            2'd1:    return div_t'(8);
            2'd2:    return div_t'(12);
            default: return div_t'(4);
        endcase
    endfunction
endpackage

// File: rtl/dsd_clkgen.sv
// Master-mode clock generator.
// Divides the master clock into a bit clock (plain capture) or a double-rate
// data clock plus a bit-rate phase reference (phase-modulated capture).
// Assumes the mode and divide inputs change only under reset.
module dsd_clkgen
    import dsd_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       pm_en,
    input  logic [1:0] ratio_sel,
    output logic       sclk_gen,
    output logic       phase_gen
);
    div_t n_div, half, quarter, cnt, pos;

    assign n_div   = ratio_div(ratio_sel);
    assign half    = n_div >> 1;
    assign quarter = n_div >> 2;
    // Position inside the current fast-clock period.
    assign pos     = (cnt >= half) ? div_t'(cnt - half) : cnt;

    // Count master cycles and register the generated clock levels.
    always_ff @(posedge clk) begin
        if (!rst_n || !master_en) begin
            cnt       <= '0;
            sclk_gen  <= 1'b0;
            phase_gen <= 1'b0;
        end else begin
            cnt       <= (cnt >= div_t'(n_div - 1'b1)) ? '0 : div_t'(cnt + 1'b1);
            sclk_gen  <= pm_en ? (pos < quarter) : (cnt < half);
            phase_gen <= pm_en & (cnt < half);
        end
    end
endmodule

// File: rtl/dsd_sync.sv
// Multi-stage synchroniser for a bundle of single-bit inputs.
// All bits see the same delay, which keeps clock, phase and data aligned.
module dsd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsd_capture.sv
// Bit recovery from the synchronised clock, phase and data lines.
// Plain mode: samples every rising clock edge.
// Phase mode: keeps the phase-high sample, then at the phase-low edge
// emits the carrying half and checks that the other half is its complement.
module dsd_capture #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pm_en,
    input  logic           pm_var,
    input  logic           s_clk,
    input  logic           s_ph,
    input  logic [NCH-1:0] s_dat,
    output logic [NCH-1:0] bits,
    output logic           valid,
    output logic           err
);
    logic           clk_d, have_first, rise;
    logic [NCH-1:0] first_h, same;

    assign rise = s_clk & ~clk_d;

    // A half pair is wrong when both halves hold the same level.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        assign same[ch] = (s_dat[ch] == first_h[ch]);
    end

    // Detect clock edges, hold the first half and emit recovered bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d      <= 1'b0;
            have_first <= 1'b0;
            first_h    <= '0;
            bits       <= '0;
            valid      <= 1'b0;
            err        <= 1'b0;
        end else begin
            clk_d <= s_clk;
            valid <= 1'b0;
            err   <= 1'b0;
            if (rise) begin
                if (!pm_en) begin
                    bits  <= s_dat;
                    valid <= 1'b1;
                end else if (s_ph) begin
                    first_h    <= s_dat;
                    have_first <= 1'b1;
                end else if (have_first) begin
                    have_first <= 1'b0;
                    bits       <= pm_var ? s_dat : first_h;
                    valid      <= 1'b1;
                    err        <= |same;
                end
            end
        end
    end
endmodule

// File: rtl/dsd_rx.sv
// Top of the one-bit stereo stream receiver.
// Picks the internal or the external clocks, synchronises them together with
// the data, and recovers one bit per channel.
// Assumes the mode inputs are static outside reset.
module dsd_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       pm_en,
    input  logic       pm_variant,
    input  logic [1:0] ratio_sel,
    input  logic       sclk_in,
    input  logic       phase_in,
    input  logic       ldata_in,
    input  logic       rdata_in,
    output logic       sclk_out,
    output logic       phase_out,
    output logic       left_bit,
    output logic       right_bit,
    output logic       bit_valid,
    output logic       pm_err
);
    localparam int NCH = 2;
    localparam int SW  = NCH + 2;

    logic           sclk_gen, phase_gen, clk_raw, ph_raw, var_eff;
    logic [SW-1:0]  raw_bus, sync_bus;
    logic [NCH-1:0] rec_bits;

    dsd_clkgen u_gen (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .pm_en(pm_en),
        .ratio_sel(ratio_sel), .sclk_gen(sclk_gen), .phase_gen(phase_gen)
    );

    // Source selection: own generator in master mode, pins otherwise.
    assign clk_raw = master_en ? sclk_gen  : sclk_in;
    assign ph_raw  = master_en ? phase_gen : phase_in;
    assign var_eff = pm_variant & ~master_en;
    assign raw_bus = {ph_raw, clk_raw, rdata_in, ldata_in};

    dsd_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    dsd_capture #(.NCH(NCH)) u_cap (
        .clk(clk), .rst_n(rst_n), .pm_en(pm_en), .pm_var(var_eff),
        .s_clk(sync_bus[NCH]), .s_ph(sync_bus[NCH+1]), .s_dat(sync_bus[NCH-1:0]),
        .bits(rec_bits), .valid(bit_valid), .err(pm_err)
    );

    assign left_bit  = rec_bits[0];
    assign right_bit = rec_bits[1];
    assign sclk_out  = sclk_gen;
    assign phase_out = phase_gen;
endmodule

// File: rtl/dsd_rx_chk.sv
// Property checker for the receiver, attached to every instance by bind.
module dsd_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic master_en,
    input logic pm_en,
    input logic sclk_out,
    input logic phase_out,
    input logic bit_valid,
    input logic pm_err
);
    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!sclk_out && !phase_out));

    // R7
    plain_no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en |=> !phase_out);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R6
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_err |-> bit_valid);

    // R6
    plain_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en |=> !pm_err);

    // R8
    phase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && pm_en && $rose(phase_out)) |-> $rose(sclk_out));
endmodule

bind dsd_rx dsd_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .pm_en(pm_en),
    .sclk_out(sclk_out), .phase_out(phase_out), .bit_valid(bit_valid),
    .pm_err(pm_err)
);

// File: tb/sim_dsd_rx.sv
// Scoreboard bench for dsd_rx.
module sim_dsd_rx;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, master_en = 1'b0, pm_en = 1'b0, pm_variant = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic s_sclk = 1'b0, s_ph = 1'b0, s_l = 1'b0, s_r = 1'b0;
    logic m_l, m_r, tog = 1'b0;
    bit   dec_on = 1'b0, tog_on = 1'b0;
    logic sclk_in, phase_in, ldata_in, rdata_in;
    logic sclk_out, phase_out, left_bit, right_bit, bit_valid, pm_err;

    assign sclk_in  = tog_on ? tog : s_sclk;
    assign phase_in = tog_on ? ~tog : s_ph;
    assign ldata_in = dec_on ? m_l : s_l;
    assign rdata_in = dec_on ? m_r : s_r;

    dsd_rx u0 (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .pm_en(pm_en),
        .pm_variant(pm_variant), .ratio_sel(ratio_sel), .sclk_in(sclk_in),
        .phase_in(phase_in), .ldata_in(ldata_in), .rdata_in(rdata_in),
        .sclk_out(sclk_out), .phase_out(phase_out), .left_bit(left_bit),
        .right_bit(right_bit), .bit_valid(bit_valid), .pm_err(pm_err)
    );

    typedef struct { logic l; logic r; logic e; string tag; } exp_t;
    exp_t  q[$];
    exp_t  mon_e;
    int    total = 0, bad = 0, vcount = 0, cyc = 0;
    int    per_exp = 4, ph_exp = 4;
    string cur_tag = "R1";

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) cyc++;
    always @(negedge clk) tog <= ~tog;

    // Monitor: pop and compare every strobed pair.
    always @(negedge clk) begin
        if (rst_n && bit_valid) begin
            vcount++;
            if (q.size() == 0) begin
                chk(0, cur_tag, "unexpected valid", 1, 0);
            end else begin
                mon_e = q.pop_front();
                chk({left_bit, right_bit, pm_err} == {mon_e.l, mon_e.r, mon_e.e},
                    mon_e.tag, "left,right,err",
                    int'({left_bit, right_bit, pm_err}), int'({mon_e.l, mon_e.r, mon_e.e}));
            end
        end
    end

    // Decoder model for master mode: follows sclk_out and phase_out.
    logic prev_s, hseen, tl, tr;
    logic [7:0] lf;
    int last_rise, last_ph;
    always @(negedge clk) begin
        if (!dec_on) begin
            prev_s = 1'b0; hseen = 1'b0; last_rise = -1; last_ph = -1;
            lf = 8'hA5; tl = 1'b1; tr = 1'b0; m_l = tl; m_r = tr;
        end else begin
            if (sclk_out && !prev_s) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == per_exp, pm_en ? "R8" : "R7", "sclk period",
                        cyc - last_rise, per_exp);
                last_rise = cyc;
                if (!pm_en) begin
                    chk(phase_out == 1'b0, "R7", "phase_out in plain", int'(phase_out), 0);
                    q.push_back('{ldata_in, rdata_in, 1'b0, "R7"});
                end else if (phase_out) begin
                    if (last_ph >= 0)
                        chk(cyc - last_ph == ph_exp, "R8", "phase period", cyc - last_ph, ph_exp);
                    last_ph = cyc;
                    hseen = 1'b1;
                end else if (hseen) begin
                    hseen = 1'b0;
                    q.push_back('{tl, tr, 1'b0, "R9"});
                end
            end else if (!sclk_out && prev_s) begin
                if (pm_en && phase_out) begin
                    m_l = ~tl; m_r = ~tr;
                end else begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    tl = lf[0]; tr = lf[3]; m_l = tl; m_r = tr;
                end
            end
            prev_s = sclk_out;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        cycles(3);
        chk(q.size() == 0, cur_tag, "items left pending", q.size(), 0);
        q.delete();
        rst_n = 1'b1;
    endtask

    // Plain slave bit: expected pair pushed, latency checked (R2).
    task automatic send_plain(logic l, logic r, logic ph, string tag);
        s_l = l; s_r = r; s_ph = ph; s_sclk = 1'b0;
        cycles(3);
        q.push_back('{l, r, 1'b0, tag});
        s_sclk = 1'b1;
        cycles(1); chk(bit_valid == 1'b0, "R2", "valid after 1 edge", int'(bit_valid), 0);
        cycles(1); chk(bit_valid == 1'b0, "R2", "valid after 2 edges", int'(bit_valid), 0);
        cycles(1); chk(bit_valid == 1'b1, "R2", "valid after 3 edges", int'(bit_valid), 1);
        chk(sclk_out == 1'b0 && phase_out == 1'b0, "R10", "slave clock outputs",
            int'({sclk_out, phase_out}), 0);
        s_sclk = 1'b0;
        cycles(2);
    endtask

    // Phase-modulated slave bit: phase-high half then phase-low half.
    task automatic send_pm(logic bl, logic br, logic vr, logic cl, logic cr, string tag);
        s_ph = 1'b1; s_l = vr ? ~bl : bl; s_r = vr ? ~br : br; s_sclk = 1'b0;
        cycles(2); s_sclk = 1'b1; cycles(2); s_sclk = 1'b0; cycles(1);
        s_ph = 1'b0; s_l = (vr ? bl : ~bl) ^ cl; s_r = (vr ? br : ~br) ^ cr;
        cycles(1);
        q.push_back('{vr ? bl ^ cl : bl, vr ? br ^ cr : br, cl | cr, tag});
        s_sclk = 1'b1;
        cycles(3); chk(bit_valid == 1'b1, tag, "valid at phase-low edge", int'(bit_valid), 1);
        s_sclk = 1'b0;
        cycles(1);
    endtask

    task automatic stop_master();
        logic p;
        p = sclk_out;
        forever begin
            @(negedge clk);
            if (p && !sclk_out) break;
            p = sclk_out;
        end
        master_en = 1'b0;
        tog_on = 1'b0;
        cycles(8);
        dec_on = 1'b0;
    endtask

    task automatic run_master(logic pm, logic [1:0] rs, int per, int ph, logic vr, string tag);
        cur_tag = tag;
        rst_n = 1'b0;
        master_en = 1'b1; pm_en = pm; ratio_sel = rs; pm_variant = vr;
        per_exp = per; ph_exp = ph;
        cycles(1);
        dec_on = 1'b1;
        tog_on = vr;
        do_reset();
        cycles(120);
        stop_master();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int v0;
        // R1 reset state
        cycles(3);
        chk({bit_valid, pm_err, left_bit, right_bit, sclk_out, phase_out} == 6'b0,
            "R1", "outputs in reset", int'({bit_valid, pm_err, left_bit, right_bit, sclk_out, phase_out}), 0);
        rst_n = 1'b1;
        cycles(1);
        chk({bit_valid, pm_err, left_bit, right_bit, sclk_out, phase_out} == 6'b0,
            "R1", "outputs after release", int'({bit_valid, pm_err, left_bit, right_bit, sclk_out, phase_out}), 0);

        // R2 plain capture, several patterns
        cur_tag = "R2";
        send_plain(1, 0, 0, "R2"); send_plain(0, 1, 0, "R2");
        send_plain(1, 1, 0, "R2"); send_plain(0, 0, 0, "R2");
        // R3 phase toggling ignored in plain mode
        cur_tag = "R3";
        send_plain(1, 0, 1, "R3"); send_plain(1, 0, 0, "R3");
        send_plain(0, 1, 1, "R3"); send_plain(1, 1, 1, "R3");

        // R11 lone phase-low edge after reset gives nothing
        cur_tag = "R11";
        pm_en = 1'b1; pm_variant = 1'b0;
        do_reset();
        v0 = vcount;
        s_ph = 1'b0; s_sclk = 1'b0; cycles(2);
        s_sclk = 1'b1; cycles(3); s_sclk = 1'b0; cycles(4);
        chk(vcount == v0, "R11", "strobes from lone half", vcount - v0, 0);

        // R4 phase-high carrier, R6 complement errors
        cur_tag = "R4";
        send_pm(1, 0, 0, 0, 0, "R4"); send_pm(0, 1, 0, 0, 0, "R4");
        send_pm(1, 1, 0, 0, 0, "R4"); send_pm(0, 0, 0, 0, 0, "R4");
        cur_tag = "R6";
        send_pm(1, 0, 0, 1, 0, "R6"); send_pm(0, 1, 0, 0, 1, "R6");
        send_pm(1, 1, 0, 0, 0, "R6");

        // R5 phase-low carrier
        cur_tag = "R5";
        pm_variant = 1'b1;
        do_reset();
        send_pm(1, 0, 1, 0, 0, "R5"); send_pm(0, 1, 1, 0, 0, "R5");
        send_pm(1, 1, 1, 0, 1, "R6"); send_pm(0, 0, 1, 0, 0, "R5");

        // R7 master plain for each divide select
        pm_en = 1'b0; pm_variant = 1'b0;
        run_master(1'b0, 2'd0, 4, 4, 1'b0, "R7");
        run_master(1'b0, 2'd1, 8, 8, 1'b0, "R7");
        run_master(1'b0, 2'd2, 12, 12, 1'b0, "R7");
        run_master(1'b0, 2'd3, 4, 4, 1'b0, "R7");
        // R8 master phase-modulated, R9 variant and pins ignored
        run_master(1'b1, 2'd0, 2, 4, 1'b1, "R9");
        run_master(1'b1, 2'd2, 6, 12, 1'b1, "R8");

        do_reset();
        cycles(4);
        finish_run();
    end
endmodule